// File: doc/BRIEF.md
# Zero-Overhead Repeat Loop Sequencer

This block runs a hardware repeat loop for a pipelined core that issues 16-bit instructions. Software first loads a first-instruction address, a last-instruction address and a 12-bit pass count. A marker instruction placed just before the loop body then arms the loop. From that point the block watches the issued instruction stream. Each time the last instruction of the body issues and at least two passes remain, the block sends the next fetch back to the first instruction and lowers the count by one. The core needs no branch instruction for this.

While the loop is armed, the block also acts as the core's exception gate. Interrupts that can wait are held from the marker instruction up to the final issue of the last instruction. Exceptions that cannot wait go through, and a flag reports that the loop state is lost. A marker that sits in the delay slot of a taken branch does not arm anything. The block also supplies the program-counter value the core shows for each instruction. Inside the loop this value follows fixed rules that differ between short and long bodies.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, `loop_active` is 0 and `loop_count` is 0. With no instruction issued, a raised `irq_req` is granted in the same cycle.
- R2: A `cfg_load` pulse updates the first address, the last address and the count only while `loop_active` is 0. A load made while the loop runs leaves `loop_count` and the loop bounds unchanged.
- R3: An issued marker (`ins_detect`=1) arms the loop when the loop is idle and no taken branch suppresses it. `loop_active` reads 1 from the next cycle on.
- R4: While the loop runs, an issue of the last address with count ≥ 2 sets `redirect`. In that cycle `nxt_addr` equals the first address, and the count falls by 1 at the clock edge.
- R5: While the loop runs, an issue of the last address with count < 2 gives `nxt_addr` = address + 2 and no redirect. From the next cycle `loop_active` is 0 and `loop_count` is 0. Every other issue gives `nxt_addr` = address + 2.
- R6: `irq_grant` is 0 from the marker cycle through the final issue of the last address. Outside that window it follows `irq_req` in the same cycle.
- R7: `nmi_grant` always follows `nmi_req`. `nmi_lost` is 1 when `nmi_req` is raised inside the R6 window.
- R8: A marker issued with `ins_dslot`=1 and `ins_br_taken`=1 does not arm the loop. With `ins_br_taken`=0 it arms the loop as in R3.
- R9: The marker instruction, the first instruction after it, and every instruction outside a running loop report `rep_pc` = address + 4.
- R10: The body length is (last − first)/2 + 1 instructions. With a length of 1 to 3 and count ≥ 2 at arming, every instruction from the second one after the marker until the loop ends reports the first address.
- R11: With a length of 4 or more and count ≥ 2 at arming, the second and third instructions after the marker report the first address and the first address + 2. All later instructions report address + 4.
- R12: With count < 2 at arming, every instruction of the loop reports address + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Load strobe for the loop bounds and count |
| cfg_start | input | AW | First body instruction address |
| cfg_end | input | AW | Last body instruction address |
| cfg_count | input | CW | Pass count |
| ins_valid | input | 1 | An instruction issues this cycle |
| ins_addr | input | AW | Address of the issuing instruction |
| ins_detect | input | 1 | Issuing instruction is the loop marker |
| ins_dslot | input | 1 | Issuing instruction sits in a branch delay slot |
| ins_br_taken | input | 1 | The branch owning that delay slot is taken |
| irq_req | input | 1 | Holdable exception request |
| nmi_req | input | 1 | Non-holdable exception request |
| nxt_addr | output | AW | Next fetch address |
| redirect | output | 1 | Fetch is sent back to the first address |
| rep_pc | output | AW | PC value reported for the issuing instruction |
| irq_grant | output | 1 | Holdable exception accepted |
| nmi_grant | output | 1 | Non-holdable exception accepted |
| nmi_lost | output | 1 | Non-holdable exception taken inside the loop window |
| loop_active | output | 1 | Loop is armed |
| loop_count | output | CW | Remaining pass count |

## Verification
The bench uses the default widths: 16-bit addresses and a 12-bit count. These widths give real address arithmetic across a 0x100-based loop, and they let small counts of 1, 2 and 3 land on both sides of the loop-back threshold. Body lengths of 1, 3, 4 and 8 sit on both sides of the short/long PC-reporting boundary. Holdable and non-holdable requests are raised inside the loop and just after it, a load is attempted mid-loop, and the marker is placed in both a taken and a not-taken delay slot.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  // position of the issuing instruction counted from the marker, saturating
  typedef logic [2:0] pos_t;
  localparam pos_t POS_SAT = 3'd4;
  // largest (last - first) byte span still counted as a short body
  localparam int SHORT_SPAN = 4;
endpackage

// File: rtl/hwloop_state.sv
module hwloop_state
  import hwloop_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] cfg_end,
  input  logic [CW-1:0] cfg_count,
  input  logic          ins_valid,
  input  logic [AW-1:0] ins_addr,
  input  logic          ins_detect,
  input  logic          ins_dslot,
  input  logic          ins_br_taken,
  output logic          active_q,
  output logic [CW-1:0] cnt_q,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] end_q,
  output pos_t          pos_q,
  output logic          short_q,
  output logic          quirk_q,
  output logic          arm,
  output logic          redirect
);
  localparam logic [CW-1:0] CNT_TWO = CW'(2);
  localparam logic [AW-1:0] SPAN    = AW'(SHORT_SPAN);

  logic          active_d, short_d, quirk_d, en;
  logic [CW-1:0] cnt_d;
  logic [AW-1:0] start_d, end_d;
  pos_t          pos_d;
  logic          end_hit, more;

  assign arm      = ins_valid & ins_detect & ~active_q & ~(ins_dslot & ins_br_taken);
  assign end_hit  = ins_valid & active_q & (ins_addr == end_q);
  assign more     = (cnt_q >= CNT_TWO);
  assign redirect = end_hit & more;
  assign en       = cfg_load | ins_valid;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    start_d  = start_q;
    end_d    = end_q;
    pos_d    = pos_q;
    short_d  = short_q;
    quirk_d  = quirk_q;
    if (cfg_load && !active_q) begin
      start_d = cfg_start;
      end_d   = cfg_end;
      cnt_d   = cfg_count;
    end
    if (arm) begin
      active_d = 1'b1;
      pos_d    = pos_t'(1);
      quirk_d  = more;
      short_d  = ((end_q - start_q) <= SPAN);
    end
    if (active_q && ins_valid) begin
      pos_d = (pos_q == POS_SAT) ? POS_SAT : pos_q + pos_t'(1);
    end
    if (end_hit) begin
      if (more) begin
        cnt_d = cnt_q - CW'(1);
      end else begin
        active_d = 1'b0;
        cnt_d    = '0;
        pos_d    = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      start_q  <= '0;
      end_q    <= '0;
      pos_q    <= '0;
      short_q  <= 1'b0;
      quirk_q  <= 1'b0;
    end else if (en) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      start_q  <= start_d;
      end_q    <= end_d;
      pos_q    <= pos_d;
      short_q  <= short_d;
      quirk_q  <= quirk_d;
    end
  end
endmodule

// File: rtl/hwloop_pcrep.sv
module hwloop_pcrep
  import hwloop_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          active_q,
  input  logic          quirk_q,
  input  logic          short_q,
  input  pos_t          pos_q,
  input  logic [AW-1:0] start_q,
  input  logic [AW-1:0] ins_addr,
  output logic [AW-1:0] rep_pc
);
  always_comb begin
    rep_pc = ins_addr + AW'(4);
    if (active_q && quirk_q) begin
      if (short_q) begin
        if (pos_q >= pos_t'(2)) rep_pc = start_q;
      end else begin
        if (pos_q == pos_t'(2))      rep_pc = start_q;
        else if (pos_q == pos_t'(3)) rep_pc = start_q + AW'(2);
      end
    end
  end
endmodule

// File: rtl/hwloop_excgate.sv
module hwloop_excgate (
  input  logic active_q,
  input  logic arm,
  input  logic irq_req,
  input  logic nmi_req,
  output logic irq_grant,
  output logic nmi_grant,
  output logic nmi_lost
);
  logic in_window;
  assign in_window = active_q | arm;
  assign irq_grant = irq_req & ~in_window;
  assign nmi_grant = nmi_req;
  assign nmi_lost  = nmi_req & in_window;
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] cfg_end,
  input  logic [CW-1:0] cfg_count,
  input  logic          ins_valid,
  input  logic [AW-1:0] ins_addr,
  input  logic          ins_detect,
  input  logic          ins_dslot,
  input  logic          ins_br_taken,
  input  logic          irq_req,
  input  logic          nmi_req,
  output logic [AW-1:0] nxt_addr,
  output logic          redirect,
  output logic [AW-1:0] rep_pc,
  output logic          irq_grant,
  output logic          nmi_grant,
  output logic          nmi_lost,
  output logic          loop_active,
  output logic [CW-1:0] loop_count
);
  logic [1:0]    rst_sync;
  logic          srst_n;
  logic          active_q, short_q, quirk_q, arm;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] start_q, end_q;
  pos_t          pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  hwloop_state #(.AW(AW), .CW(CW)) state_i (
    .clk(clk), .srst_n(srst_n),
    .cfg_load(cfg_load), .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_count(cfg_count),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_detect(ins_detect),
    .ins_dslot(ins_dslot), .ins_br_taken(ins_br_taken),
    .active_q(active_q), .cnt_q(cnt_q), .start_q(start_q), .end_q(end_q),
    .pos_q(pos_q), .short_q(short_q), .quirk_q(quirk_q),
    .arm(arm), .redirect(redirect)
  );

  hwloop_pcrep #(.AW(AW)) pcrep_i (
    .active_q(active_q), .quirk_q(quirk_q), .short_q(short_q), .pos_q(pos_q),
    .start_q(start_q), .ins_addr(ins_addr), .rep_pc(rep_pc)
  );

  hwloop_excgate excgate_i (
    .active_q(active_q), .arm(arm), .irq_req(irq_req), .nmi_req(nmi_req),
    .irq_grant(irq_grant), .nmi_grant(nmi_grant), .nmi_lost(nmi_lost)
  );

  assign nxt_addr    = redirect ? start_q : ins_addr + AW'(2);
  assign loop_active = active_q;
  assign loop_count  = cnt_q;
endmodule

// File: rtl/hwloop_chk.sv
module hwloop_chk #(
  parameter int AW = 16,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          srst_n,
  input logic          ins_valid,
  input logic [AW-1:0] ins_addr,
  input logic          ins_detect,
  input logic          ins_dslot,
  input logic          ins_br_taken,
  input logic          nmi_req,
  input logic          nmi_grant,
  input logic          irq_grant,
  input logic          redirect,
  input logic [AW-1:0] nxt_addr,
  input logic          loop_active,
  input logic [CW-1:0] loop_count,
  input logic [AW-1:0] start_q,
  input logic [AW-1:0] end_q
);
  p_bounds_locked_r2: assert property (@(posedge clk) disable iff (!srst_n)
    loop_active |=> $stable(start_q) && $stable(end_q));

  p_redirect_target_r4: assert property (@(posedge clk) disable iff (!srst_n)
    redirect |-> (nxt_addr == start_q));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!srst_n)
    redirect |=> (loop_count == $past(loop_count) - CW'(1)));

  p_exit_clear_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (loop_active && ins_valid && ins_addr == end_q && loop_count < CW'(2))
      |=> (!loop_active && loop_count == '0));

  p_irq_held_r6: assert property (@(posedge clk) disable iff (!srst_n)
    loop_active |-> !irq_grant);

  p_nmi_pass_r7: assert property (@(posedge clk) disable iff (!srst_n)
    nmi_req |-> nmi_grant);

  p_taken_slot_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (ins_valid && ins_detect && ins_dslot && ins_br_taken && !loop_active) |=> !loop_active);
endmodule

bind hwloop_ctrl hwloop_chk #(.AW(AW), .CW(CW)) chk_i (
  .clk(clk), .srst_n(srst_n),
  .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_detect(ins_detect),
  .ins_dslot(ins_dslot), .ins_br_taken(ins_br_taken),
  .nmi_req(nmi_req), .nmi_grant(nmi_grant), .irq_grant(irq_grant),
  .redirect(redirect), .nxt_addr(nxt_addr),
  .loop_active(loop_active), .loop_count(loop_count),
  .start_q(start_q), .end_q(end_q)
);

// File: tb/hwloop_ctrl_tb.sv
module hwloop_ctrl_tb_top;
  localparam int AW = 16;
  localparam int CW = 12;
  localparam int CLK_PERIOD = 10;

  localparam int K_NXT = 0, K_RED = 1, K_PC = 2, K_IRQ = 3, K_NMIG = 4,
                 K_NMIL = 5, K_ACT = 6, K_CNT = 7;

  typedef struct {
    string req;
    int    kind;
    int    exp;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_load;
  logic [AW-1:0] cfg_start, cfg_end;
  logic [CW-1:0] cfg_count;
  logic ins_valid, ins_detect, ins_dslot, ins_br_taken, irq_req, nmi_req;
  logic [AW-1:0] ins_addr;
  logic [AW-1:0] nxt_addr, rep_pc;
  logic redirect, irq_grant, nmi_grant, nmi_lost, loop_active;
  logic [CW-1:0] loop_count;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  item_t sb[$];
  event  chk_ev;

  // reference state built from the requirements
  bit m_act, m_short, m_quirk;
  int m_cnt, m_pos, m_start, m_end;
  int last_nxt;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwloop_ctrl #(.AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_start(cfg_start),
    .cfg_end(cfg_end), .cfg_count(cfg_count), .ins_valid(ins_valid),
    .ins_addr(ins_addr), .ins_detect(ins_detect), .ins_dslot(ins_dslot),
    .ins_br_taken(ins_br_taken), .irq_req(irq_req), .nmi_req(nmi_req),
    .nxt_addr(nxt_addr), .redirect(redirect), .rep_pc(rep_pc),
    .irq_grant(irq_grant), .nmi_grant(nmi_grant), .nmi_lost(nmi_lost),
    .loop_active(loop_active), .loop_count(loop_count)
  );

  function automatic int actual(int kind);
    case (kind)
      K_NXT:   return int'(nxt_addr);
      K_RED:   return int'(redirect);
      K_PC:    return int'(rep_pc);
      K_IRQ:   return int'(irq_grant);
      K_NMIG:  return int'(nmi_grant);
      K_NMIL:  return int'(nmi_lost);
      K_ACT:   return int'(loop_active);
      default: return int'(loop_count);
    endcase
  endfunction

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        item_t it;
        int act;
        it = sb.pop_front();
        act = actual(it.kind);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic push(string req, int kind, int exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_load = 1'b0; ins_valid = 1'b0; ins_detect = 1'b0; ins_dslot = 1'b0;
    ins_br_taken = 1'b0; irq_req = 1'b0; nmi_req = 1'b0;
  endtask

  task automatic do_load(int s, int e, int c);
    @(negedge clk);
    ins_valid = 1'b0; irq_req = 1'b0; nmi_req = 1'b0;
    cfg_load = 1'b1; cfg_start = AW'(s); cfg_end = AW'(e); cfg_count = CW'(c);
    #(CLK_PERIOD/4);
    push("R2", K_CNT, m_cnt);
    push("R2", K_ACT, int'(m_act));
    -> chk_ev;
    if (!m_act) begin
      m_start = s; m_end = e; m_cnt = c;
    end
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic issue(int a, bit det, bit ds, bit tk, bit irq, bit nmi);
    bit arm, win, endhit;
    int pc;
    string pcreq;
    @(negedge clk);
    cfg_load = 1'b0;
    ins_valid = 1'b1; ins_addr = AW'(a); ins_detect = det; ins_dslot = ds;
    ins_br_taken = tk; irq_req = irq; nmi_req = nmi;
    #(CLK_PERIOD/4);
    arm    = det && !m_act && !(ds && tk);
    win    = m_act || arm;
    endhit = m_act && (a == m_end);
    last_nxt = (endhit && m_cnt >= 2) ? m_start : ((a + 2) & 16'hFFFF);
    pc = (a + 4) & 16'hFFFF;
    pcreq = "R9";
    if (m_act && m_pos >= 2) begin
      if (!m_quirk) pcreq = "R12";
      else if (m_short) begin pcreq = "R10"; pc = m_start; end
      else begin
        pcreq = "R11";
        if (m_pos == 2) pc = m_start;
        else if (m_pos == 3) pc = m_start + 2;
      end
    end
    push((endhit && m_cnt >= 2) ? "R4" : "R5", K_NXT, last_nxt);
    push((endhit && m_cnt >= 2) ? "R4" : "R5", K_RED, int'(endhit && m_cnt >= 2));
    push(pcreq, K_PC, pc);
    push("R6", K_IRQ, int'(irq && !win));
    push("R7", K_NMIG, int'(nmi));
    push("R7", K_NMIL, int'(nmi && win));
    push(det ? "R8" : "R3", K_ACT, int'(m_act));
    push("R4", K_CNT, m_cnt);
    -> chk_ev;
    // model update at the coming edge
    if (m_act) m_pos = (m_pos >= 4) ? 4 : m_pos + 1;
    if (endhit) begin
      if (m_cnt >= 2) m_cnt = m_cnt - 1;
      else begin m_act = 1'b0; m_cnt = 0; m_pos = 0; end
    end
    if (arm) begin
      m_act = 1'b1; m_pos = 1; m_quirk = (m_cnt >= 2);
      m_short = ((m_end - m_start) <= 4);
    end
  endtask

  task automatic run_prog(int s, int len, int c, bit ds, bit tk, int irq_k, int nmi_k, int load_k);
    int a;
    do_load(s, s + 2 * (len - 1), c);
    issue(s - 2, 1'b1, ds, tk, irq_k == 0, nmi_k == 0);
    if (ds && tk) begin
      // fetch continues at the branch target; the loop must stay idle (R8)
      for (int i = 0; i < 3; i++) issue(16'h0400 + 2 * i, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      idle();
      return;
    end
    a = last_nxt;
    for (int k = 1; k < 200; k++) begin
      if (k == load_k) do_load(16'h0200, 16'h0210, 7);
      issue(a, 1'b0, 1'b0, 1'b0, k == irq_k, k == nmi_k);
      a = last_nxt;
      if (!m_act) begin
        issue(a, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);  // holdable request released (R6)
        break;
      end
    end
    idle();
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_load = 1'b0; cfg_start = '0; cfg_end = '0; cfg_count = '0;
    ins_valid = 1'b0; ins_addr = '0; ins_detect = 1'b0; ins_dslot = 1'b0;
    ins_br_taken = 1'b0; irq_req = 1'b0; nmi_req = 1'b0;
    m_act = 1'b0; m_short = 1'b0; m_quirk = 1'b0;
    m_cnt = 0; m_pos = 0; m_start = 0; m_end = 0; last_nxt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state and open exception gate
    irq_req = 1'b1;
    #(CLK_PERIOD/4);
    push("R1", K_ACT, 0);
    push("R1", K_CNT, 0);
    push("R1", K_IRQ, 1);
    -> chk_ev;
    idle();
    run_prog(16'h0100, 1, 3, 1'b0, 1'b0, -1, -1, -1);   // R10 single-instruction body
    run_prog(16'h0100, 3, 2, 1'b0, 1'b0, 2, -1, -1);    // R6 interrupt mid-loop
    run_prog(16'h0100, 4, 2, 1'b0, 1'b0, -1, 3, -1);    // R11 long body, R7 nmi
    run_prog(16'h0100, 8, 3, 1'b0, 1'b0, 5, 9, 4);      // R2 ignored load mid-loop
    run_prog(16'h0100, 2, 2, 1'b1, 1'b1, -1, -1, -1);   // R8 taken branch
    run_prog(16'h0100, 2, 2, 1'b1, 1'b0, 0, -1, -1);    // R8 not taken, R6 at marker
    run_prog(16'h0100, 4, 1, 1'b0, 1'b0, -1, -1, -1);   // R12 count below two
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule